// File: doc/BRIEF.md
# Daisy-Chain SPI Configuration Target

This block is the configuration port of one device in a string of identical devices that share a single chip select and pass serial data from one to the next. Each device holds a 24-bit shift stage. Bits from the serial input enter at the bottom, and the top bit drives the serial output. A frame therefore comes out of the device 24 serial clocks after it went in and moves on to the next device in the string. A host that talks to N devices shifts N frames back to back inside one chip-select window. The frame meant for the device farthest along the string goes first.

When chip select is released, the device decodes whatever 24 bits its stage holds. A frame can do one of four things. It can write a 16-bit word into a register of the currently selected bank, or it can set the bank selector. A frame with the read prefix requests a read: if reads are unlocked, the stage is reloaded with the requested address and that register's contents, and the next window shifts this response out. All-ones frames are ignored, so they can serve as filler for clocking responses out. The serial pins are sampled by a faster system clock and acted on through edge detection. The registers are small banked arrays held inside the block.

Top module: `dsr_cfg_target`

## Requirements
- R1: After reset the shift stage and `sdo` are 0, the bank selector is 0, the read lock is 0, and register r of bank b holds the 16-bit value b*256 + r.
- R2: While `cs_n` is low, `sdi` is shifted in MSB first on each rising `sclk`. `sdo` shows the stage's top bit. It is refreshed on each falling `sclk` and on the falling `cs_n`, so a device delays the serial data by exactly 24 `sclk` cycles.
- R3: A frame is decoded only at the rising `cs_n`, and only if a nonzero multiple of 24 rising `sclk` edges was seen in that window. Any other window changes no register.
- R4: A frame {addr[23:16], data[15:0]} with addr below REGS_PER_BANK writes data into that register of the selected bank.
- R5: Writing address 0xFD from any bank sets the bank selector from data[1:0]. Reading 0xFD returns the selector, zero-extended.
- R6: Writing address 0xFC sets the read lock from data[0]. Reading 0xFC returns the lock in bit 0.
- R7: A frame {0xFE, 0x00, addr} decoded while the lock is 0 reloads the stage with {addr, contents}. The following window shifts this response out.
- R8: Addresses that are not implemented (at or above REGS_PER_BANK other than 0xFC/0xFD, or any address while the selector is at or above NUM_BANKS) read as 0x0000. Writes to them are ignored.
- R9: A frame whose top byte is 0xFF has no effect. The stage keeps the frame, so all-ones filler comes back as all ones.
- R10: A read request decoded while the lock is 1 loads nothing. The stage keeps the request frame, and that frame is what shifts out next.
- R11: If `cs_n` goes low again one system clock after a read request is decoded, the first `sdo` bit of the new window is already the response MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select shared by the string |
| sdi | input | 1 | Serial data in, from the host or the previous device |
| sdo | output | 1 | Serial data out, to the next device or the host |

## Verification
Two events can fall into adjacent system-clock cycles: the end-of-window decode that reloads the stage, and the start of the next window, which copies the stage's top bit onto `sdo`. The bench provokes this by raising chip select for a single system clock between each read request and the following readout. It judges the outcome by whether the first bit returned is the response MSB rather than the request MSB. A second overlap arises in a two-device string: one window carries a lock write to the first device and a filler frame to the second. The bench confirms that the second device's reads still succeed while the first device's reads return the request frame itself.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int FRAME_W = 24;

  localparam logic [7:0] ADDR_PAGE = 8'hFD;
  localparam logic [7:0] ADDR_LOCK = 8'hFC;
  localparam logic [7:0] ADDR_NOP  = 8'hFF;
  localparam logic [7:0] PFX_READ  = 8'hFE;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } frame_op_t;

  // Classify a complete frame held in the shift stage.
  function automatic frame_op_t frame_kind(input logic [FRAME_W-1:0] f);
    if (f[23:16] == PFX_READ && f[15:8] == 8'h00) return OP_READ;
    if (f[23:16] == ADDR_NOP) return OP_NONE;
    return OP_WRITE;
  endfunction

  // Address a frame refers to: low byte for reads, top byte for writes.
  function automatic logic [7:0] frame_addr(input logic [FRAME_W-1:0] f,
                                            input frame_op_t op);
    return (op == OP_READ) ? f[7:0] : f[23:16];
  endfunction

  // Reset contents of register r in bank b.
  function automatic logic [15:0] reg_init(input int unsigned b,
                                           input int unsigned r);
    logic [7:0] bb;
    logic [7:0] rr;
    bb = 8'(b);
    rr = 8'(r);
    return {bb, rr};
  endfunction

endpackage

// File: rtl/dsr_shifter.sv
module dsr_shifter import dsr_pkg::*; #(
  parameter int W = FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         sdi,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] frame,
  output logic         sdo,
  output logic         frame_ok,
  output logic         sclk_rise,
  output logic         sclk_fall,
  output logic         cs_rise,
  output logic         cs_fall
);
  localparam int CNT_W = $clog2(W);

  logic         sclk_q, cs_q, seen;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0] sh;

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign cs_rise   = cs_n & ~cs_q;
  assign cs_fall   = ~cs_n & cs_q;
  assign frame     = sh;
  assign frame_ok  = cs_rise && seen && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      seen   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      sdo    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        cnt  <= '0;
        seen <= 1'b0;
        sdo  <= sh[W-1];
      end else if (!cs_n) begin
        if (sclk_rise) begin
          sh   <= {sh[W-2:0], sdi};
          cnt  <= (cnt == CNT_W'(W-1)) ? '0 : cnt + 1'b1;
          seen <= 1'b1;
        end
        if (sclk_fall) sdo <= sh[W-1];
      end
      if (load_en) sh <= load_val;
    end
  end

endmodule

// File: rtl/dsr_regbank.sv
module dsr_regbank import dsr_pkg::*; #(
  parameter int NUM_BANKS     = 3,
  parameter int REGS_PER_BANK = 4,
  parameter int PAGE_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] bank,
  input  logic [7:0]        addr,
  input  logic [15:0]       wdata,
  output logic              hit,
  output logic [15:0]       rdata
);
  localparam int TOTAL = NUM_BANKS * REGS_PER_BANK;

  logic [TOTAL*16-1:0] flat;
  int unsigned sel;

  assign hit = (32'(bank) < NUM_BANKS) && (32'(addr) < REGS_PER_BANK);
  assign sel = 32'(bank) * REGS_PER_BANK + 32'(addr);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < REGS_PER_BANK; r++) begin : g_reg
      logic [15:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= reg_init(b, r);
        else if (wr_en && bank == PAGE_W'(b) && addr == 8'(r)) q <= wdata;
      end
      assign flat[(b*REGS_PER_BANK+r)*16 +: 16] = q;
    end
  end

  always_comb begin
    rdata = 16'h0000;
    if (hit) rdata = flat[sel*16 +: 16];
  end

endmodule

// File: rtl/dsr_cfg_target.sv
module dsr_cfg_target import dsr_pkg::*; #(
  parameter int NUM_BANKS     = 3,
  parameter int REGS_PER_BANK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo
);
  localparam int PAGE_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [FRAME_W-1:0] frame, load_val;
  logic        frame_ok, load_en;
  logic        sclk_rise, sclk_fall, cs_rise, cs_fall;
  frame_op_t   op;
  logic [7:0]  tgt_addr;
  logic [15:0] bank_rdata, rd_word;
  logic        bank_hit, wr_evt, page_wr, lock_wr;
  logic [PAGE_W-1:0] page_q;
  logic        rd_lock;

  dsr_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load_en(load_en), .load_val(load_val), .frame(frame), .sdo(sdo),
    .frame_ok(frame_ok), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  dsr_regbank #(.NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK),
                .PAGE_W(PAGE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_evt), .bank(page_q),
    .addr(tgt_addr), .wdata(frame[15:0]), .hit(bank_hit), .rdata(bank_rdata)
  );

  always_comb begin
    op       = frame_kind(frame);
    tgt_addr = frame_addr(frame, op);
    if (tgt_addr == ADDR_PAGE)      rd_word = 16'(page_q);
    else if (tgt_addr == ADDR_LOCK) rd_word = {15'b0, rd_lock};
    else if (bank_hit)              rd_word = bank_rdata;
    else                            rd_word = 16'h0000;
  end

  assign wr_evt   = frame_ok && (op == OP_WRITE);
  assign page_wr  = wr_evt && (tgt_addr == ADDR_PAGE);
  assign lock_wr  = wr_evt && (tgt_addr == ADDR_LOCK);
  assign load_en  = frame_ok && (op == OP_READ) && !rd_lock;
  assign load_val = {tgt_addr, rd_word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      rd_lock <= 1'b0;
    end else begin
      if (page_wr) page_q  <= frame[PAGE_W-1:0];
      if (lock_wr) rd_lock <= frame[0];
    end
  end

endmodule

// File: rtl/dsr_cfg_target_chk.sv
module dsr_cfg_target_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sdo,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic         cs_rise,
  input logic         cs_fall,
  input logic         frame_ok,
  input logic         load_en,
  input logic         rd_lock,
  input logic [W-1:0] frame
);

  // R2
  sdo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk_fall && !cs_n) || cs_fall) |=> (sdo == $past(frame[W-1])));

  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((sclk_fall && !cs_n) || cs_fall) |=> $stable(sdo));

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sclk_rise && !cs_n) && !load_en) |=> $stable(frame));

  // R3
  decode_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> cs_rise);

  // R3
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> frame_ok);

  // R10
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !rd_lock);

endmodule

bind dsr_cfg_target dsr_cfg_target_chk #(.W(24)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
  .cs_fall(cs_fall), .frame_ok(frame_ok), .load_en(load_en),
  .rd_lock(rd_lock), .frame(frame)
);

// File: tb/dsr_cfg_target_tb_top.sv
`timescale 1ns/1ps
module dsr_cfg_target_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo_i, sdo_j;
  always #2.5 clk = ~clk;

  // Two devices: dut_i receives host data, dut_j returns data to host.
  dsr_cfg_target dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                        .sdi(sdi), .sdo(sdo_i));
  dsr_cfg_target dut_j (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                        .sdi(sdo_i), .sdo(sdo_j));

  int checks = 0, errors = 0;
  bit known, done = 0;
  logic [23:0] m_out [2];
  logic [15:0] m_reg [2][4][4];
  logic [1:0]  m_page [2];
  bit          m_lock [2];

  function automatic logic [15:0] m_rd(int d, logic [7:0] a);
    if (a == 8'hFD) return {14'b0, m_page[d]};
    if (a == 8'hFC) return {15'b0, m_lock[d]};
    if (m_page[d] < 2'd3 && a < 8'd4) return m_reg[d][m_page[d]][a[1:0]];
    return 16'h0000;
  endfunction

  task automatic apply(int d, logic [23:0] f);
    m_out[d] = f;
    if (f[23:16] == 8'hFE && f[15:8] == 8'h00) begin
      if (!m_lock[d]) m_out[d] = {f[7:0], m_rd(d, f[7:0])};
    end else if (f[23:16] == 8'hFF) begin
    end else if (f[23:16] == 8'hFD) m_page[d] = f[1:0];
    else if (f[23:16] == 8'hFC) m_lock[d] = f[0];
    else if (f[23:16] < 8'd4 && m_page[d] < 2'd3)
      m_reg[d][m_page[d]][f[17:16]] = f[15:0];
  endtask

  task automatic chk24(string tag, string who, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %06h expected %06h", tag, who, act, exp);
    end
  endtask

  // Caller is at a negedge of clk. fj goes first (for dut_j).
  task automatic win(logic [23:0] fj, logic [23:0] fi, int nbits, int gap, string tag);
    logic [47:0] tx, rx;
    tx = {fj, fi};
    rx = '0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      sdi = tx[47-k];
      repeat (2) @(negedge clk);
      rx[47-k] = sdo_j;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
    if (nbits == 48) begin
      if (known) begin
        chk24(tag, "dut_j", rx[47:24], m_out[1]);
        chk24(tag, "dut_i", rx[23:0], m_out[0]);
      end
      apply(1, fj);
      apply(0, fi);
      known = 1;
    end else if (nbits != 0) known = 0;
  endtask

  function automatic logic [7:0] addr_of(int k);
    if (k < 6) return 8'(k);
    return (k == 6) ? 8'hFC : 8'hFD;
  endfunction

  function automatic logic [23:0] rq(logic [7:0] a);
    return {8'hFE, 8'h00, a};
  endfunction

  // Reads every address of every page on both devices.
  task automatic sweep(string tag);
    for (int p = 0; p < 4; p++) begin
      win({8'hFD, 16'(p)}, {8'hFD, 16'(p)}, 48, 3, "R5");
      for (int k = 0; k < 8; k++) begin
        win(rq(addr_of(k)), rq(addr_of((k + 3) % 8)), 48, 1, tag);
        win(24'hFFFFFF, 24'hFFFFFF, 48, 3, tag); // R11: 1-cycle CS gap above
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_out[d] = '0; m_page[d] = '0; m_lock[d] = 0;
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 4; r++) m_reg[d][b][r] = 16'(b * 256 + r);
    end
    known = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state visible at the serial output
    checks++;
    if (sdo_j !== 1'b0) begin
      errors++;
      $display("FAIL R1 sdo after reset: actual %0b expected 0", sdo_j);
    end
    win(24'hFFFFFF, 24'hFFFFFF, 48, 4, "R1");
    // R9 R2: filler returns unchanged after one 24-bit delay per device
    win(24'hFFFFFF, 24'hFFFFFF, 48, 4, "R9 R2");

    // R1 R7 R8: reset values across all pages and addresses
    sweep("R1 R7 R8");

    // R4 R8: writes on every valid page, including unimplemented addresses
    for (int p = 0; p < 3; p++) begin
      win({8'hFD, 16'(p)}, {8'hFD, 16'(p)}, 48, 3, "R5");
      for (int a = 0; a < 6; a++)
        win({8'(a), 16'h5A00 ^ 16'(p * 16 + a)}, {8'(a), 16'hC300 ^ 16'(p * 32 + a)},
            48, 3, "R4 R8");
    end
    // write on invalid page 3 is dropped
    win({8'hFD, 16'd3}, {8'hFD, 16'd3}, 48, 3, "R5");
    win({8'h01, 16'hDEAD}, {8'h02, 16'hBEEF}, 48, 3, "R8");
    sweep("R4 R7 R8");

    // R6 R10: lock dut_i only; dut_j gets a 0xFF-address frame (R9)
    win({8'hFF, 16'h1234}, {8'hFC, 16'h0001}, 48, 3, "R6 R9");
    win(rq(8'h02), rq(8'h02), 48, 1, "R10");
    win(24'hFFFFFF, 24'hFFFFFF, 48, 3, "R10");
    win(rq(8'hFC), rq(8'hFC), 48, 1, "R6 R10");
    win(24'hFFFFFF, 24'hFFFFFF, 48, 3, "R6 R10");
    win({8'hFC, 16'h0000}, {8'hFC, 16'h0000}, 48, 3, "R6");
    win(rq(8'hFC), rq(8'hFC), 48, 1, "R6");
    win(24'hFFFFFF, 24'hFFFFFF, 48, 3, "R6");

    // R3: a 47-clock window and a clockless window must not decode
    win({8'hFD, 16'd0}, {8'hFD, 16'd0}, 48, 3, "R5");
    win({8'h00, 16'hBEEF}, {8'h00, 16'hBEEF}, 47, 3, "R3");
    win(24'hFFFFFF, 24'hFFFFFF, 48, 3, "R3");
    win(24'hFFFFFF, 24'hFFFFFF, 0, 3, "R3");
    win(rq(8'h00), rq(8'h00), 48, 1, "R3");
    win(24'hFFFFFF, 24'hFFFFFF, 48, 3, "R3");
    sweep("R3 R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule